// File: doc/BRIEF.md
# I2C Slave Status Flag Unit

This block watches already-synchronized SCL and SDA levels and keeps six I2C status flags that a processor reads as one status word. It finds bus conditions (START, repeated START, STOP), shifts in the one or two address bytes that follow each START, and compares them with a programmed 7-bit or 10-bit own address. It also recognizes the general call address and the START byte, and it records the transfer direction taken from the first address byte.

During slave transmit, the block flags a not-acknowledge from the master. When the controller acts as bus master, it flags lost arbitration. Events raise flags as they happen. A pulse on the read strobe clears the event flags. Dropping the enable clears every flag. Shifting of data beyond the address bytes and generation of the master clock are handled elsewhere.

Top module: `i2c_slv_flags`

## Requirements
- R1: After reset the status word is 0. In the cycle after `en` is sampled low, all six bits are 0, including the general-call and direction bits.
- R2: In 7-bit mode (`ten_bit`=0, slave mode), a first byte whose bits [7:1] equal `own_addr[6:0]` sets status bit 0 (address match). Bytes are shifted in MSB first, one bit per SCL rising edge.
- R3: In 10-bit mode, bit 0 is set only when both address bytes match: the first byte's bits [7:1] equal {11110, `own_addr[9:8]`} and the second byte equals `own_addr[7:0]`. After the first byte alone, bit 0 stays 0.
- R4: With `gc_en`=1, a first byte of 0x00 sets status bit 1 (general call) with direction bit 2 equal to 0. The transaction then counts as addressed.
- R5: With `gc_en`=1, a first byte of 0x01 (START byte) sets bit 1 with bit 2 equal to 1. It does not make the transaction addressed.
- R6: With `gc_en`=0, first bytes 0x00 and 0x01 leave bit 1 at 0. Bits 1 and 2 are rewritten after the first byte of every transaction.
- R7: Status bit 2 (direction, 1 = master reads) takes the LSB of the first byte after each START. Later bytes do not change it.
- R8: In slave mode, a STOP (SDA rising while SCL is high) or a repeated START (SDA falling while SCL is high inside a transaction) during an addressed transaction sets status bit 4.
- R9: In slave mode, when the transaction is addressed and bit 2 is 1, an SDA level of 1 on the ninth SCL rise of a data byte sets status bit 5 (NAK).
- R10: In master mode (`master_mode`=1), an SCL rise with `sda_drive`=1 and SDA sampled 0 sets status bit 3 (arbitration lost). If SDA is sampled 1, bit 3 stays 0.
- R11: A `stat_rd` pulse clears bits 0, 3, 4 and 5 in the next cycle and leaves bits 1 and 2 unchanged. An event at the same edge as the read keeps its bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Controller enable; low clears all flags and tracking state |
| master_mode | input | 1 | 1 = master (arbitration check), 0 = slave (address flags) |
| ten_bit | input | 1 | 1 = 10-bit own address, 0 = 7-bit |
| gc_en | input | 1 | Enables general call and START byte recognition |
| own_addr | input | 10 | Own slave address (bits [6:0] used in 7-bit mode) |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level |
| sda_drive | input | 1 | Level the master side is driving on SDA (1 = released) |
| stat_rd | input | 1 | Status read strobe, one cycle |
| status | output | 6 | {nak, stop_rstr, arb_lost, dir_rd, gen_call, addr_match} |

## Verification
A wrong bit counter or shift register shows up one cycle after the eighth SCL rise of the first byte: the match, general-call and direction bits come out wrong, or the match bit rises a byte early in 10-bit mode. Losing the addressed state shows up only at the next STOP or repeated START, or on the ninth rise of a read data byte, because that is where bits 4 and 5 depend on it. A fault in the clear path shows up in the cycle after a read, as a bit that survives the read or as a general-call or direction bit that is wrongly dropped.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR10_W = 10;
  localparam int STAT_W   = 6;

  localparam int ST_MATCH = 0;
  localparam int ST_GC    = 1;
  localparam int ST_DIR   = 2;
  localparam int ST_ARB   = 3;
  localparam int ST_STOP  = 4;
  localparam int ST_NAK   = 5;

  // first-byte pattern of a 10-bit address: fixed prefix plus two top bits
  function automatic logic [BYTE_W-2:0] ten_hdr(input logic [ADDR10_W-1:0] a);
    return {5'b11110, a[ADDR10_W-1:BYTE_W]};
  endfunction

  function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] s,
                                                 input logic b);
    return {s[BYTE_W-2:0], b};
  endfunction
endpackage

// File: rtl/i2cf_line_mon.sv
module i2cf_line_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign start_ev = scl & scl_q & sda_q & ~sda;
  assign stop_ev  = scl & scl_q & ~sda_q & sda;
  assign scl_rise = scl & ~scl_q;
endmodule

// File: rtl/i2cf_addr_track.sv
module i2cf_addr_track
  import i2cf_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int AW = ADDR10_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ten_bit,
  input  logic          gc_en,
  input  logic [AW-1:0] own_addr,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic          scl_rise,
  input  logic          sda,
  output logic          byte_done,
  output logic          first_done,
  output logic          first_lsb,
  output logic          addr_hit,
  output logic          gc_hit,
  output logic          sb_hit,
  output logic          data_ack,
  output logic          addressed
);
  localparam int CNT_W = $clog2(BW + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BW - 1);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BW);
  localparam logic [1:0] IDX_MAX = 2'd3;

  logic [CNT_W-1:0] bit_cnt;
  logic [BW-1:0]    shreg;
  logic [BW-1:0]    next_bits;
  logic [1:0]       byte_idx;
  logic [1:0]       data_start;
  logic             in_xfer, hdr_ok;
  logic             ack_clk, second_done, hdr_m, m7, m10;

  assign next_bits   = shift_in(shreg, sda);
  assign byte_done   = in_xfer & scl_rise & (bit_cnt == LAST_BIT);
  assign ack_clk     = in_xfer & scl_rise & (bit_cnt == ACK_BIT);
  assign first_done  = byte_done & (byte_idx == 2'd0);
  assign second_done = byte_done & (byte_idx == 2'd1);
  assign first_lsb   = next_bits[0];

  assign m7    = ~ten_bit & first_done & (next_bits[BW-1:1] == own_addr[BW-2:0]);
  assign hdr_m =  ten_bit & first_done & (next_bits[BW-1:1] == ten_hdr(own_addr));
  assign m10   =  ten_bit & second_done & hdr_ok & (next_bits == own_addr[BW-1:0]);
  assign addr_hit = m7 | m10;
  assign gc_hit   = gc_en & first_done & (next_bits == BW'(0));
  assign sb_hit   = gc_en & first_done & (next_bits == BW'(1));

  assign data_start = ten_bit ? 2'd2 : 2'd1;
  assign data_ack   = ack_clk & (byte_idx >= data_start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      shreg     <= '0;
      byte_idx  <= '0;
      in_xfer   <= 1'b0;
      hdr_ok    <= 1'b0;
      addressed <= 1'b0;
    end else if (!en) begin
      bit_cnt   <= '0;
      shreg     <= '0;
      byte_idx  <= '0;
      in_xfer   <= 1'b0;
      hdr_ok    <= 1'b0;
      addressed <= 1'b0;
    end else if (start_ev) begin
      bit_cnt   <= '0;
      byte_idx  <= '0;
      in_xfer   <= 1'b1;
      hdr_ok    <= 1'b0;
      addressed <= 1'b0;
    end else if (stop_ev) begin
      in_xfer   <= 1'b0;
      addressed <= 1'b0;
    end else if (scl_rise && in_xfer) begin
      if (bit_cnt == ACK_BIT) begin
        bit_cnt <= '0;
        if (byte_idx != IDX_MAX) byte_idx <= byte_idx + 2'd1;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
        shreg   <= next_bits;
      end
      hdr_ok    <= hdr_ok | hdr_m;
      addressed <= addressed | addr_hit | gc_hit;
    end
  end
endmodule

// File: rtl/i2cf_flag_reg.sv
module i2cf_flag_reg
  import i2cf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              master_mode,
  input  logic              stat_rd,
  input  logic              ev_match,
  input  logic              ev_first,
  input  logic              first_gc,
  input  logic              first_lsb,
  input  logic              ev_stop,
  input  logic              nak_cand,
  input  logic              ev_arb,
  output logic [STAT_W-1:0] status
);
  logic match_q, gc_q, dir_q, arb_q, stop_q, nak_q;
  logic slave, keep, ev_nak;

  assign slave  = ~master_mode;
  assign keep   = ~stat_rd;
  assign ev_nak = slave & dir_q & nak_cand;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {match_q, gc_q, dir_q, arb_q, stop_q, nak_q} <= '0;
    end else if (!en) begin
      {match_q, gc_q, dir_q, arb_q, stop_q, nak_q} <= '0;
    end else begin
      match_q <= (slave & ev_match) | (match_q & keep);
      arb_q   <= ev_arb | (arb_q & keep);
      stop_q  <= (slave & ev_stop) | (stop_q & keep);
      nak_q   <= ev_nak | (nak_q & keep);
      if (slave && ev_first) begin
        gc_q  <= first_gc;
        dir_q <= first_lsb;
      end
    end
  end

  always_comb begin
    status          = '0;
    status[ST_MATCH] = match_q;
    status[ST_GC]    = gc_q;
    status[ST_DIR]   = dir_q;
    status[ST_ARB]   = arb_q;
    status[ST_STOP]  = stop_q;
    status[ST_NAK]   = nak_q;
  end
endmodule

// File: rtl/i2c_slv_flags.sv
module i2c_slv_flags
  import i2cf_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                master_mode,
  input  logic                ten_bit,
  input  logic                gc_en,
  input  logic [ADDR10_W-1:0] own_addr,
  input  logic                scl_in,
  input  logic                sda_in,
  input  logic                sda_drive,
  input  logic                stat_rd,
  output logic [STAT_W-1:0]   status
);
  logic start_ev, stop_ev, scl_rise;
  logic byte_done, first_done, first_lsb;
  logic addr_hit, gc_hit, sb_hit, data_ack, addressed;
  logic ev_stop, ev_arb, nak_cand;

  i2cf_line_mon u_mon (
    .clk(clk), .rst_n(rst_n), .scl(scl_in), .sda(sda_in),
    .start_ev(start_ev), .stop_ev(stop_ev), .scl_rise(scl_rise)
  );

  i2cf_addr_track #(.BW(BYTE_W), .AW(ADDR10_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .en(en), .ten_bit(ten_bit), .gc_en(gc_en),
    .own_addr(own_addr), .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .sda(sda_in), .byte_done(byte_done),
    .first_done(first_done), .first_lsb(first_lsb), .addr_hit(addr_hit),
    .gc_hit(gc_hit), .sb_hit(sb_hit), .data_ack(data_ack),
    .addressed(addressed)
  );

  // named events for the flag register and the checker
  assign ev_stop  = addressed & (start_ev | stop_ev);
  assign nak_cand = addressed & data_ack & sda_in;
  assign ev_arb   = master_mode & scl_rise & sda_drive & ~sda_in;

  i2cf_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .en(en), .master_mode(master_mode),
    .stat_rd(stat_rd), .ev_match(addr_hit), .ev_first(first_done),
    .first_gc(gc_hit | sb_hit), .first_lsb(first_lsb), .ev_stop(ev_stop),
    .nak_cand(nak_cand), .ev_arb(ev_arb), .status(status)
  );
endmodule

// File: rtl/i2cf_checker.sv
module i2cf_checker
  import i2cf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              master_mode,
  input logic              stat_rd,
  input logic [STAT_W-1:0] status,
  input logic              byte_done,
  input logic              first_done,
  input logic              ev_arb
);
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (status == '0)); // R1
  AST_MATCH_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_MATCH]) |-> $past(byte_done)); // R3
  AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !first_done) |=> $stable(status[ST_DIR])); // R7
  AST_GC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !first_done) |=> $stable(status[ST_GC])); // R6
  AST_NAK_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_NAK]) |-> $past(status[ST_DIR])); // R9
  AST_ARB_MASTER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_ARB]) |-> $past(master_mode)); // R10
  AST_READ_CLEARS_ARB: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ev_arb) |=> !status[ST_ARB]); // R11
  AST_EVENT_BEATS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ev_arb) |=> status[ST_ARB]); // R11
endmodule

bind i2c_slv_flags i2cf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .master_mode(master_mode),
  .stat_rd(stat_rd), .status(status), .byte_done(byte_done),
  .first_done(first_done), .ev_arb(ev_arb)
);

// File: tb/i2c_slv_flags_bench.sv
module i2c_slv_flags_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, master_mode = 1'b0, ten_bit = 1'b0, gc_en = 1'b0;
  logic [9:0] own_addr = '0;
  logic       scl = 1'b1, sda = 1'b1, sda_drive = 1'b1, stat_rd = 1'b0;
  logic [5:0] status;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  i2c_slv_flags u_i2c_slv_flags (
    .clk(clk), .rst_n(rst_n), .en(en), .master_mode(master_mode),
    .ten_bit(ten_bit), .gc_en(gc_en), .own_addr(own_addr), .scl_in(scl),
    .sda_in(sda), .sda_drive(sda_drive), .stat_rd(stat_rd), .status(status)
  );

  // status = {nak, stop, arb, dir, gc, match}
  typedef struct packed {
    logic       ten;
    logic       gce;
    logic [9:0] own;
    logic [1:0] nb;
    logic [7:0] b1;
    logic [7:0] b2;
    logic [5:0] exp_addr;
    logic [5:0] exp_stop;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 10'h02A, 2'd1, 8'h54, 8'h00, 6'h01, 6'h11}, // R2 write
    '{1'b0, 1'b0, 10'h02A, 2'd1, 8'h55, 8'h00, 6'h05, 6'h15}, // R2 R7 read
    '{1'b0, 1'b0, 10'h02A, 2'd1, 8'h56, 8'h00, 6'h00, 6'h00}, // R2 miss
    '{1'b0, 1'b1, 10'h02A, 2'd1, 8'h00, 8'h00, 6'h02, 6'h12}, // R4
    '{1'b0, 1'b1, 10'h02A, 2'd1, 8'h01, 8'h00, 6'h06, 6'h06}, // R5
    '{1'b0, 1'b0, 10'h02A, 2'd1, 8'h00, 8'h00, 6'h00, 6'h00}, // R6
    '{1'b1, 1'b0, 10'h2A5, 2'd2, 8'hF4, 8'hA5, 6'h01, 6'h11}, // R3 hit
    '{1'b1, 1'b0, 10'h2A5, 2'd2, 8'hF4, 8'hA4, 6'h00, 6'h00}  // R3 miss
  };

  task automatic check(input string req, input logic [5:0] exp);
    n_chk++;
    if (status !== exp) begin
      n_bad++;
      $display("FAIL %s: status=%h expected=%h", req, status, exp);
    end
  endtask

  task automatic lines(input logic c, input logic d);
    @(negedge clk);
    scl = c;
    sda = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_start();
    lines(1'b1, 1'b1); lines(1'b1, 1'b0); lines(1'b0, 1'b0);
  endtask

  task automatic bus_restart();
    lines(1'b0, 1'b1); lines(1'b1, 1'b1); lines(1'b1, 1'b0); lines(1'b0, 1'b0);
  endtask

  task automatic bus_stop();
    lines(1'b0, 1'b0); lines(1'b1, 1'b0); lines(1'b1, 1'b1);
  endtask

  task automatic bus_bit(input logic b);
    lines(1'b0, b); lines(1'b1, b); lines(1'b0, b);
  endtask

  task automatic bus_byte(input logic [7:0] v, input logic ack);
    for (int i = 7; i >= 0; i--) bus_bit(v[i]);
    bus_bit(ack);
  endtask

  task automatic do_read();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: status=%h expected=done", status);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(2);
    check("R1 reset", 6'h00);
    rst_n = 1'b1;
    en = 1'b1;
    idle(2);

    // table walk
    for (int v = 0; v < NV; v++) begin
      ten_bit = VEC[v].ten; gc_en = VEC[v].gce; own_addr = VEC[v].own;
      do_read();
      bus_start();
      bus_byte(VEC[v].b1, 1'b0);
      if (VEC[v].nb == 2'd2) bus_byte(VEC[v].b2, 1'b0);
      idle(2);
      check("R2-table addr phase", VEC[v].exp_addr);
      bus_stop();
      idle(2);
      check("R8-table after stop", VEC[v].exp_stop);
    end

    // R3: header alone does not match
    ten_bit = 1'b1; gc_en = 1'b0; own_addr = 10'h2A5;
    do_read();
    bus_start(); bus_byte(8'hF4, 1'b0); idle(2);
    check("R3 header only", 6'h00);
    bus_stop(); idle(2);

    // R7: later byte does not change direction
    ten_bit = 1'b0; own_addr = 10'h02A;
    do_read();
    bus_start(); bus_byte(8'h54, 1'b0); bus_byte(8'hFF, 1'b0); idle(2);
    check("R7 dir kept", 6'h01);
    // R8: repeated START while addressed
    bus_restart(); idle(2);
    check("R8 repeated start", 6'h11);
    bus_stop(); idle(2);

    // R9: NAK on read data byte
    do_read();
    bus_start(); bus_byte(8'h55, 1'b0); bus_byte(8'hFF, 1'b1); idle(2);
    check("R9 nak", 6'h25);
    // R11: read clears events, keeps direction
    do_read();
    check("R11 read clear", 6'h04);
    bus_stop(); idle(2);
    do_read();

    // R11: general call bit survives a read
    gc_en = 1'b1;
    bus_start(); bus_byte(8'h01, 1'b0); bus_stop(); idle(2);
    do_read();
    check("R11 gc kept", 6'h06);

    // R1: disable clears all
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1;
    check("R1 disable", 6'h00);

    // R10: arbitration
    master_mode = 1'b1; sda_drive = 1'b1;
    lines(1'b0, 1'b1); lines(1'b1, 1'b1); idle(2);
    check("R10 no loss", 6'h00);
    lines(1'b0, 1'b0); lines(1'b1, 1'b0); idle(2);
    check("R10 lost", 6'h08);
    do_read();
    check("R11 arb cleared", 6'h00);
    // R11: event coincides with read
    lines(1'b0, 1'b0);
    @(negedge clk); scl = 1'b1; stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    check("R11 event wins", 6'h08);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule